// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous static RAM whose every request input is sampled on the rising clock edge. It has a registered read path and a built-in four-beat burst sequencer. The stored word is 36 bits wide and split into four 9-bit lanes, each holding eight data bits and one parity bit. A host opens an access by pulsing either of two address strobes. The block then captures the address and the state of its three select inputs. Further beats of the same four-word group are produced by an internal 2-bit counter that moves only while the advance input is asserted.

Writes can be masked per lane or forced onto the whole word. A read issued in the cycle right after a write returns the freshly written data, even though the array update is still in flight. The read pipeline, including the select state, is two registers deep. Output enable and the burst-order select act without a clock.

Top module: `burst_sram_pipe`

## Requirements
- R1: While reset is high and right after it, `rvalid` is 0 and `rdata` is all zeros.
- R2: In the cycle where `strobe_cpu_n` or `strobe_ctl_n` is low, `addr` is taken as the access address and the beat counter restarts at 0. A read issued in cycle n appears on `rdata` with `rvalid` high in cycle n+2, so the first word can be captured on the third rising edge. Every later beat follows one cycle after the previous one.
- R3: With `order_lin` = 1, the low two address bits of beat c are (s + c) mod 4, where s is the loaded low two bits. The upper address bits stay fixed.
- R4: With `order_lin` = 0, the low two address bits of beat c are s XOR c. The upper address bits stay fixed.
- R5: In a cycle with no strobe and `advance_n` high, the access repeats the address of the previous cycle.
- R6: The beat counter steps by one for each cycle with no strobe and `advance_n` low, and it returns to the starting address after four steps.
- R7: Lane k (k = 0..3) is bits [9k+8:9k]. It is written only when `lane_we_n[k]` is 0 and `lane_en_n` is 0. The other lanes keep their old contents.
- R8: While `lane_en_n` is 1 and `all_we_n` is 1, `lane_we_n` has no effect, and the cycle is a read.
- R9: `all_we_n` = 0 writes all four lanes, whatever `lane_en_n` and `lane_we_n` are.
- R10: A read of an address in the cycle right after a write to it returns the merged new word.
- R11: The block is selected when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0 at a strobe. An unselected strobe drops `rvalid` two cycles later and makes writes have no effect until the next selected strobe.
- R12: With `oe_n` high, `rvalid` is 0 and `rdata` is zero, without waiting for a clock edge.
- R13: A write cycle gives `rvalid` = 0 two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address taken at a strobe |
| wdata | input | 36 | Write word, four 9-bit lanes |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| strobe_cpu_n | input | 1 | Address strobe, host side, active low |
| strobe_ctl_n | input | 1 | Address strobe, controller side, active low |
| advance_n | input | 1 | Step the burst counter, active low |
| lane_we_n | input | 4 | Per-lane write requests, active low |
| lane_en_n | input | 1 | Enables the per-lane requests, active low |
| all_we_n | input | 1 | Write every lane, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | 36 | Read word, zero when not valid |
| rvalid | output | 1 | Read word present and enabled |

## Verification
The bench builds the block with ADDR_W = 6, a 64-word array small enough that every location is written and read back in turn. At this size it is also practical to apply all sixteen lane masks to a single word, every combination of the three select inputs, and every start offset in both burst orders, with wrap-around. All expected words come from an arithmetic reference model of the burst order and the lane merge. That model lets the bench also cover the two hard cases: write-then-read forwarding inside bursts, and writes made while unselected.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic       valid;
        lane_mask_t mask;
        word_t      data;
    } wr_req_t;

    // Low address bits of a beat, from the loaded offset and the beat count.
    function automatic beat_t beat_offset(beat_t start, beat_t count, burst_order_e ord);
        beat_t r;
        if (ord == ORD_LINEAR) r = beat_t'(start + count);
        else                   r = start ^ count;
        return r;
    endfunction

    // Lanes written in a cycle; the whole-word request overrides the rest.
    function automatic lane_mask_t decode_lanes(logic all_n, logic en_n, lane_mask_t lane_n);
        lane_mask_t r;
        if (!all_n)     r = '1;
        else if (!en_n) r = ~lane_n;
        else            r = '0;
        return r;
    endfunction

    function automatic word_t merge_lanes(word_t old_w, word_t new_w, lane_mask_t m);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/burst_addr_unit.sv
`timescale 1ns/1ps
module burst_addr_unit
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  burst_order_e      ord,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              sel_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_sel
);

    logic [ADDR_W-1:0] base_q, base_n;
    beat_t             cnt_q, cnt_n;
    logic              sel_q, sel_n;

    always_comb begin
        if (load) begin
            base_n = ext_addr;
            cnt_n  = '0;
            sel_n  = sel_in;
        end else begin
            base_n = base_q;
            cnt_n  = adv ? beat_t'(cnt_q + 2'd1) : cnt_q;
            sel_n  = sel_q;
        end
    end

    assign acc_addr = {base_n[ADDR_W-1:BEAT_W], beat_offset(base_n[BEAT_W-1:0], cnt_n, ord)};
    assign acc_sel  = sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
            sel_q  <= sel_n;
        end
    end

    // R11
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !sel_in) |=> !sel_q);

    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> ($stable(base_q) && $stable(cnt_q)));

    // R6
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && adv) |=> (cnt_q == beat_t'($past(cnt_q) + 2'd1)));

endmodule

// File: rtl/burst_store.sv
`timescale 1ns/1ps
module burst_store
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rd_en,
    input  lane_mask_t        wr_mask,
    input  word_t             wdata,
    output word_t             rd_word,
    output logic              rd_hit
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t             mem [DEPTH];
    wr_req_t           pend;
    logic [ADDR_W-1:0] pend_addr;
    word_t             arr_word, fwd_word;
    logic              wr_en;

    assign wr_en = |wr_mask;

    // Pending write is merged into a read of the same address.
    always_comb begin
        arr_word = mem[acc_addr];
        if (pend.valid && pend_addr == acc_addr)
            fwd_word = merge_lanes(arr_word, pend.data, pend.mask);
        else
            fwd_word = arr_word;
    end

    always_ff @(posedge clk) begin
        if (pend.valid)
            mem[pend_addr] <= merge_lanes(mem[pend_addr], pend.data, pend.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            pend_addr <= '0;
            rd_word   <= '0;
            rd_hit    <= 1'b0;
        end else begin
            pend.valid <= wr_en;
            pend.mask  <= wr_mask;
            pend.data  <= wdata;
            pend_addr  <= acc_addr;
            rd_hit     <= rd_en;
            if (rd_en) rd_word <= fwd_word;
        end
    end

    // R13
    write_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_hit);

endmodule

// File: rtl/burst_out_stage.sv
`timescale 1ns/1ps
module burst_out_stage
    import burst_sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  oe_n,
    input  word_t d_in,
    input  logic  v_in,
    output word_t rdata,
    output logic  rvalid
);

    word_t out_q;
    logic  out_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= v_in;
            if (v_in) out_q <= d_in;
        end
    end

    assign rvalid = out_v && !oe_n;
    assign rdata  = rvalid ? out_q : '0;

endmodule

// File: rtl/burst_sram_pipe.sv
`timescale 1ns/1ps
module burst_sram_pipe
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       wdata,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic [3:0]        lane_we_n,
    input  logic              lane_en_n,
    input  logic              all_we_n,
    input  logic              oe_n,
    input  logic              order_lin,
    output logic [35:0]       rdata,
    output logic              rvalid
);

    logic              load, adv, sel_in, acc_sel, rd_en, rd_hit;
    logic [ADDR_W-1:0] acc_addr;
    lane_mask_t        wr_mask;
    word_t             rd_word;

    assign load   = !strobe_cpu_n || !strobe_ctl_n;
    assign adv    = !advance_n;
    assign sel_in = !sel_a_n && sel_b && !sel_c_n;

    burst_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv      (adv),
        .ord      (burst_order_e'(order_lin)),
        .ext_addr (addr),
        .sel_in   (sel_in),
        .acc_addr (acc_addr),
        .acc_sel  (acc_sel)
    );

    assign wr_mask = acc_sel ? decode_lanes(all_we_n, lane_en_n, lane_we_n) : '0;
    assign rd_en   = acc_sel && (wr_mask == '0);

    burst_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .acc_addr (acc_addr),
        .rd_en    (rd_en),
        .wr_mask  (wr_mask),
        .wdata    (wdata),
        .rd_word  (rd_word),
        .rd_hit   (rd_hit)
    );

    burst_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .oe_n   (oe_n),
        .d_in   (rd_word),
        .v_in   (rd_hit),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ##1 (rvalid || oe_n));

    // R11
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_sel |=> ##1 !rvalid);

endmodule

// File: tb/tb_burst_sram_pipe.sv
`timescale 1ns/1ps
module tb_burst_sram_pipe;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wdata = '0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          lane_en_n = 1'b1, all_we_n = 1'b1, oe_n = 1'b0, order_lin = 1'b1;
    logic [35:0]   rdata;
    logic          rvalid;

    burst_sram_pipe #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .advance_n(advance_n), .lane_we_n(lane_we_n), .lane_en_n(lane_en_n),
        .all_we_n(all_we_n), .oe_n(oe_n), .order_lin(order_lin),
        .rdata(rdata), .rvalid(rvalid)
    );

    always #10 clk = ~clk;

    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [35:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;
    bit          m_sel = 1'b0;
    bit          pv_valid = 1'b0;
    logic [35:0] pv_data = '0;
    string       pv_tag = "R1";
    bit          probe_oe = 1'b0;

    function automatic logic [35:0] pat(int a, int s);
        return (36'(a) * 36'h0_0101_0101) ^ (36'(s) * 36'h5_A5A3_C3C5) ^ 36'h9_0000_0007;
    endfunction

    task automatic chk(bit ok, string tag, logic [36:0] act, logic [36:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit ld_cpu, bit ld_ctl, bit adv, logic [AW-1:0] a, logic [35:0] d,
                        logic [3:0] lwe, bit len, bit awe, logic [2:0] cs, string tag);
        logic [3:0]    m;
        logic [1:0]    off;
        logic [AW-1:0] ea;
        bit            v;
        logic [35:0]   ed;
        strobe_cpu_n = !ld_cpu;
        strobe_ctl_n = !ld_ctl;
        advance_n    = !adv;
        addr         = a;
        wdata        = d;
        lane_we_n    = lwe;
        lane_en_n    = len;
        all_we_n     = awe;
        {sel_a_n, sel_b, sel_c_n} = cs;
        if (ld_cpu || ld_ctl) begin
            m_base = a; m_cnt = 2'd0; m_sel = (cs == 3'b010);
        end else if (adv) begin
            m_cnt = m_cnt + 2'd1;
        end
        off = order_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        ea  = {m_base[AW-1:2], off};
        m   = !awe ? 4'hF : (!len ? ~lwe : 4'h0);
        v = 1'b0; ed = '0;
        if (m_sel && m != 4'h0) begin
            for (int i = 0; i < 4; i++)
                if (m[i]) ref_mem[ea][i*9 +: 9] = d[i*9 +: 9];
            tag = "R13";
        end else if (m_sel) begin
            v = 1'b1; ed = ref_mem[ea];
        end else begin
            tag = "R11";
        end
        @(posedge clk);
        @(negedge clk);
        if (probe_oe) begin
            oe_n = 1'b1; #1;
            chk(rvalid == 1'b0 && rdata == '0, "R12", {rvalid, rdata}, 37'h0);
            oe_n = 1'b0; #1;
        end
        chk(rvalid == pv_valid && rdata == pv_data, pv_tag, {rvalid, rdata}, {pv_valid, pv_data});
        pv_valid = v; pv_data = ed; pv_tag = tag;
    endtask

    task automatic rd(logic [AW-1:0] a, bit use_ctl, string tag);
        step(!use_ctl, use_ctl, 1'b0, a, '0, 4'hF, 1'b1, 1'b1, 3'b010, tag);
    endtask

    task automatic nxt(bit adv, string tag);
        step(1'b0, 1'b0, adv, '0, '0, 4'hF, 1'b1, 1'b1, 3'b010, tag);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(rvalid == 1'b0 && rdata == '0, "R1", {rvalid, rdata}, 37'h0);

        // R9: fill every word with a whole-word write, alternating strobes
        for (int a = 0; a < DEPTH; a++)
            step(a % 2 == 0, a % 2 == 1, 1'b0, AW'(a), pat(a, 0), 4'hF, 1'b1, 1'b0, 3'b010, "R9");

        // R2: read back every word
        for (int a = 0; a < DEPTH; a++)
            rd(AW'(a), a % 2 == 1, "R2");

        // R3 / R4 / R6: every start offset, both orders, with wrap
        for (int md = 0; md < 2; md++) begin
            order_lin = md[0];
            for (int s = 0; s < 16; s++) begin
                rd(AW'(s), 1'b0, md[0] ? "R3" : "R4");
                for (int b = 1; b <= 4; b++)
                    nxt(1'b1, (b == 4) ? "R6" : (md[0] ? "R3" : "R4"));
            end
        end
        order_lin = 1'b1;

        // R5: hold without advance
        rd(AW'(21), 1'b1, "R5");
        nxt(1'b0, "R5");
        nxt(1'b0, "R5");
        nxt(1'b1, "R5");
        nxt(1'b0, "R5");

        // R7 / R10: every lane mask, read right after write then again
        for (int m = 0; m < 16; m++) begin
            step(1'b1, 1'b0, 1'b0, AW'(40), pat(40, m + 1), ~4'(m), 1'b0, 1'b1, 3'b010, "R7");
            nxt(1'b0, "R10");
            nxt(1'b0, "R7");
        end

        // R8: lane requests without lane enable
        step(1'b1, 1'b0, 1'b0, AW'(41), pat(41, 99), 4'h0, 1'b1, 1'b1, 3'b010, "R8");
        nxt(1'b0, "R8");

        // R9: whole-word override
        step(1'b0, 1'b1, 1'b0, AW'(42), pat(42, 7), 4'hF, 1'b1, 1'b0, 3'b010, "R9");
        nxt(1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, AW'(43), pat(43, 8), 4'b1110, 1'b0, 1'b0, 3'b010, "R9");
        nxt(1'b0, "R9");

        // R11: all select combinations, then ignored write while unselected
        for (int c = 0; c < 8; c++)
            step(1'b1, 1'b0, 1'b0, AW'(5), '0, 4'hF, 1'b1, 1'b1, 3'(c), "R11");
        step(1'b1, 1'b0, 1'b0, AW'(6), pat(6, 55), 4'hF, 1'b1, 1'b0, 3'b110, "R11");
        step(1'b0, 1'b0, 1'b1, '0, pat(6, 56), 4'h0, 1'b0, 1'b0, 3'b010, "R11");
        rd(AW'(6), 1'b0, "R11");
        rd(AW'(7), 1'b0, "R11");

        // R10: burst write then burst read, both orders
        for (int md = 0; md < 2; md++) begin
            order_lin = md[0];
            step(1'b1, 1'b0, 1'b0, AW'(49), pat(49, 20 + md), 4'hF, 1'b1, 1'b0, 3'b010, "R10");
            for (int b = 1; b < 4; b++)
                step(1'b0, 1'b0, 1'b1, '0, pat(b, 30 + md), 4'h0, 1'b0, 1'b1, 3'b010, "R10");
            rd(AW'(49), 1'b1, "R10");
            for (int b = 1; b < 4; b++)
                nxt(1'b1, "R10");
        end
        order_lin = 1'b1;

        // R12: output enable gating without a clock edge
        rd(AW'(12), 1'b0, "R2");
        probe_oe = 1'b1;
        rd(AW'(13), 1'b0, "R2");
        probe_oe = 1'b0;
        nxt(1'b0, "R2");
        nxt(1'b0, "R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule